// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Enable Controller

This block keeps the protection state and the write permission of a small serial EEPROM. A command decoder outside the block hands it single-cycle strobes: set or clear the write-enable latch, commit a status write, commit an array write, and start or advance a status read. The block decides whether each committed write may run, times the self-timed programming cycle with an internal counter, and builds the status byte that the serial output logic shifts out.

The status byte carries four constant ones in bits 7..4, the two protect bits in bits 3..2, the latch in bit 1 and the busy flag in bit 0. A status write takes only its bits 3..2. The new protect value is held in a shadow register and appears only when the programming cycle ends, so a status read during the cycle shows the old protection. The two protect bits select how much of the upper address space is protected. A separate address input lets the rest of the chip ask whether an address is protected.

Top module: `eeStatusCtl`

## Requirements
- R1: After reset the status byte reads 8'hF0: bits 7..4 are 1, protect bits (3..2) are 00, latch (bit 1) is 0 and busy (bit 0) is 0.
- R2: A write-enable strobe sets the latch (status bit 1) while the write-protect input is high and no cycle is running.
- R3: A write-disable strobe clears the latch.
- R4: While the write-protect input is low, the latch is cleared on every clock, and a write-enable strobe has no effect.
- R5: A status or array write commit made while the latch is clear, or while write-protect is low, starts no cycle and leaves the protect bits unchanged.
- R6: An accepted status write sets busy on the next clock and clears the latch. The protect bits keep their old value until busy falls, then take bits 3..2 of the written byte.
- R7: Busy stays high for exactly CYC_LEN clocks after the commit clock.
- R8: Once a cycle has started, taking write-protect low does not shorten it.
- R9: An array write commit clears the latch in every case. Its programming strobe is raised, and a cycle is started, only if the target address is unprotected.
- R10: Protect bits 00 protect nothing, 01 protect the top quarter (the two address MSBs are 11), 10 protect the top half (address MSB is 1), and 11 protect every address. The protected output reflects the check address.
- R11: A status read starts with bit 7 and moves down one bit per shift strobe. The shift after bit 0 returns to bit 7.
- R12: A write-enable strobe that arrives while busy is high is ignored.
- R13: Only bits 3..2 of a status write byte matter. The other bits do not change the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset, asynchronous |
| wpN | input | 1 | Write-protect pin, low blocks writes |
| cmdWren | input | 1 | Write-enable command strobe |
| cmdWrdi | input | 1 | Write-disable command strobe |
| statWrCommit | input | 1 | Status write commit strobe, last data bit received |
| statWrData | input | 8 | Byte received for the status write |
| arrWrCommit | input | 1 | Array write commit strobe |
| arrWrAddr | input | ADDR_W | Target address of the array write |
| chkAddr | input | ADDR_W | Address to test against the protection |
| rdStart | input | 1 | Start a status read at bit 7 |
| rdShift | input | 1 | Advance the status read by one bit |
| statusByte | output | 8 | Current status byte |
| statBit | output | 1 | Status bit currently selected for serial output |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Write cycle busy |
| bpBits | output | 2 | Protect bits in effect |
| addrProtected | output | 1 | chkAddr lies in the protected region |
| arrProgStart | output | 1 | Array programming may start (combinational, in the commit cycle) |

## Verification
The assertions assume the decoder gives one-cycle strobes and never commits a status write and an array write in the same cycle. They also assume a read start and a shift do not arrive together. The bench drives every strobe for exactly one clock, from the falling edge, and issues one command at a time, so it stays inside these limits. Write-protect is the only input the bench moves at arbitrary points, including in the middle of a cycle. The properties must hold for any such movement.

// File: rtl/eeStatusPkg.sv
package eeStatusPkg;
  // bit positions inside the status byte
  localparam int BUSY_POS = 0;
  localparam int LATCH_POS = 1;
  localparam int PROT_LO = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic shadowLd;   // capture incoming protect bits
    logic bpCommit;   // copy shadow into the live protect bits
  } bpStrobes_t;
endpackage

// File: rtl/eeProtDecode.sv
module eeProtDecode #(
  parameter int ADDR_W = 9
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int MSB = ADDR_W - 1;

  always_comb begin
    unique case (bp)
      2'b00: hit = 1'b0;
      2'b01: hit = addr[MSB] & addr[MSB-1];
      2'b10: hit = addr[MSB];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/eeStatusCtrl.sv
module eeStatusCtrl
  import eeStatusPkg::*;
#(
  parameter int CYC_LEN = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wpN,
  input  logic       cmdWren,
  input  logic       cmdWrdi,
  input  logic       statWrCommit,
  input  logic       arrWrCommit,
  input  logic       arrProt,
  output logic       wel,
  output logic       wip,
  output logic       arrProgStart,
  output bpStrobes_t strobes
);
  localparam int CNT_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYC_LEN - 1);

  logic [CNT_W-1:0] cnt;
  logic pendStat;
  logic statAccept, arrAccept, cycEnd;

  assign statAccept = statWrCommit && wel && wpN && !wip;
  assign arrAccept  = arrWrCommit && !statWrCommit && wel && wpN && !wip && !arrProt;
  assign cycEnd     = wip && (cnt == '0);

  assign arrProgStart      = arrAccept;
  assign strobes.shadowLd  = statAccept;
  assign strobes.bpCommit  = cycEnd && pendStat;

  // write-enable latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             wel <= 1'b0;
    else if (!wpN)                         wel <= 1'b0;
    else if (statWrCommit || arrWrCommit)  wel <= 1'b0;
    else if (cmdWrdi)                      wel <= 1'b0;
    else if (cmdWren && !wip)              wel <= 1'b1;
  end

  // self-timed cycle counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wip      <= 1'b0;
      cnt      <= '0;
      pendStat <= 1'b0;
    end else if (statAccept || arrAccept) begin
      wip      <= 1'b1;
      cnt      <= LOAD_VAL;
      pendStat <= statAccept;
    end else if (cycEnd) begin
      wip      <= 1'b0;
      pendStat <= 1'b0;
    end else if (wip) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R4
  wp_clears_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wpN |=> !wel);
  // R6
  commit_clears_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWrCommit || arrWrCommit) |=> !wel);
  // R7
  busy_needs_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(statWrCommit || arrWrCommit));
  // R9
  prot_blocks_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (arrWrCommit && !statWrCommit && arrProt && !wip) |=> !wip);
  // R12
  wren_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wip && !wel) |=> !wel);
endmodule

// File: rtl/eeStatusData.sv
module eeStatusData
  import eeStatusPkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  bpStrobes_t        strobes,
  input  logic [7:0]        statWrData,
  input  logic              wel,
  input  logic              wip,
  input  logic              rdStart,
  input  logic              rdShift,
  input  logic [ADDR_W-1:0] arrWrAddr,
  input  logic [ADDR_W-1:0] chkAddr,
  output logic [7:0]        statusByte,
  output logic              statBit,
  output logic [1:0]        bpBits,
  output logic              arrProt,
  output logic              chkProt
);
  logic [1:0] bpQ, bpShadow;
  logic [2:0] rdPtr;
  logic [ADDR_W-1:0] probeAddr [2];
  logic [1:0] probeHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpQ      <= 2'b00;
      bpShadow <= 2'b00;
    end else begin
      if (strobes.shadowLd) bpShadow <= statWrData[PROT_LO+1:PROT_LO];
      if (strobes.bpCommit) bpQ <= bpShadow;
    end
  end

  always_comb begin
    statusByte = 8'hF0;
    statusByte[PROT_LO+1:PROT_LO] = bpQ;
    statusByte[LATCH_POS] = wel;
    statusByte[BUSY_POS]  = wip;
  end

  assign bpBits = bpQ;

  // serial read pointer: 3-bit down counter wraps 0 -> 7
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rdPtr <= 3'd7;
    else if (rdStart) rdPtr <= 3'd7;
    else if (rdShift) rdPtr <= rdPtr - 3'd1;
  end

  assign statBit = statusByte[rdPtr];

  assign probeAddr[0] = arrWrAddr;
  assign probeAddr[1] = chkAddr;

  for (genvar i = 0; i < 2; i++) begin : g_probe
    eeProtDecode #(.ADDR_W(ADDR_W)) u_dec (
      .bp  (bpQ),
      .addr(probeAddr[i]),
      .hit (probeHit[i])
    );
  end

  assign arrProt = probeHit[0];
  assign chkProt = probeHit[1];

  // R6
  bp_hold_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    wip |-> $stable(bpQ));
  // R11
  rd_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdShift && !rdStart && rdPtr == 3'd0) |=> (rdPtr == 3'd7));
  // R10
  full_prot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bpQ == 2'b11) |-> (arrProt && chkProt));
endmodule

// File: rtl/eeStatusCtl.sv
module eeStatusCtl
  import eeStatusPkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int CYC_LEN = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpN,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              statWrCommit,
  input  logic [7:0]        statWrData,
  input  logic              arrWrCommit,
  input  logic [ADDR_W-1:0] arrWrAddr,
  input  logic [ADDR_W-1:0] chkAddr,
  input  logic              rdStart,
  input  logic              rdShift,
  output logic [7:0]        statusByte,
  output logic              statBit,
  output logic              wel,
  output logic              wip,
  output logic [1:0]        bpBits,
  output logic              addrProtected,
  output logic              arrProgStart
);
  bpStrobes_t strobes;
  logic arrProt;

  eeStatusCtrl #(.CYC_LEN(CYC_LEN)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wpN         (wpN),
    .cmdWren     (cmdWren),
    .cmdWrdi     (cmdWrdi),
    .statWrCommit(statWrCommit),
    .arrWrCommit (arrWrCommit),
    .arrProt     (arrProt),
    .wel         (wel),
    .wip         (wip),
    .arrProgStart(arrProgStart),
    .strobes     (strobes)
  );

  eeStatusData #(.ADDR_W(ADDR_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .statWrData(statWrData),
    .wel       (wel),
    .wip       (wip),
    .rdStart   (rdStart),
    .rdShift   (rdShift),
    .arrWrAddr (arrWrAddr),
    .chkAddr   (chkAddr),
    .statusByte(statusByte),
    .statBit   (statBit),
    .bpBits    (bpBits),
    .arrProt   (arrProt),
    .chkProt   (addrProtected)
  );
endmodule

// File: tb/tb_eeStatusCtl.sv
module tb_eeStatusCtl;
  localparam int ADDR_W  = 9;
  localparam int CYC_LEN = 20;

  logic clk = 1'b0, rstN = 1'b0, wpN = 1'b1;
  logic cmdWren = 0, cmdWrdi = 0, statWrCommit = 0, arrWrCommit = 0;
  logic rdStart = 0, rdShift = 0;
  logic [7:0] statWrData = '0;
  logic [ADDR_W-1:0] arrWrAddr = '0, chkAddr = '0;
  logic [7:0] statusByte;
  logic statBit, wel, wip, addrProtected, arrProgStart;
  logic [1:0] bpBits;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  eeStatusCtl #(.ADDR_W(ADDR_W), .CYC_LEN(CYC_LEN)) dut (.*);

  // protect decode vectors: {bp[1:0], addr[8:0], expected}
  localparam int NVEC = 9;
  localparam logic [11:0] VEC [NVEC] = '{
    {2'b00, 9'd511, 1'b0}, {2'b01, 9'd383, 1'b0}, {2'b01, 9'd384, 1'b1},
    {2'b01, 9'd511, 1'b1}, {2'b10, 9'd255, 1'b0}, {2'b10, 9'd256, 1'b1},
    {2'b11, 9'd0,   1'b1}, {2'b11, 9'd200, 1'b1}, {2'b00, 9'd0,   1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobeWren();
    @(negedge clk) cmdWren = 1; @(negedge clk) cmdWren = 0;
  endtask
  task automatic strobeWrdi();
    @(negedge clk) cmdWrdi = 1; @(negedge clk) cmdWrdi = 0;
  endtask
  task automatic statWrite(input logic [7:0] d);
    @(negedge clk) begin statWrCommit = 1; statWrData = d; end
    @(negedge clk) statWrCommit = 0;
  endtask
  task automatic arrWrite(input logic [ADDR_W-1:0] a, output logic go);
    @(negedge clk) begin arrWrCommit = 1; arrWrAddr = a; end
    #1 go = arrProgStart;
    @(negedge clk) arrWrCommit = 0;
  endtask
  // counts clocks until busy falls; sampled on falling edges
  task automatic busyLen(output int n);
    n = 0;
    while (wip && n < 1000) begin @(negedge clk); n++; end
  endtask
  task automatic setBp(input logic [1:0] b);
    int n;
    strobeWren();
    statWrite({4'h0, b, 2'b00});
    busyLen(n);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic go;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 reset status", statusByte, 8'hF0);

    strobeWren();
    check("R2 wren sets latch", statusByte, 8'hF2);
    strobeWrdi();
    check("R3 wrdi clears latch", wel, 0);

    strobeWren();
    @(negedge clk) wpN = 0;
    @(negedge clk);
    check("R4 wp low clears latch", wel, 0);
    strobeWren();
    check("R4 wren ignored under wp", wel, 0);
    wpN = 1;

    statWrite(8'h0C);
    check("R5 status write without latch no busy", wip, 0);
    check("R5 protect bits unchanged", bpBits, 2'b00);

    strobeWren();
    wpN = 0;
    statWrite(8'h0C);
    wpN = 1;
    check("R5 status write under wp no busy", wip, 0);

    strobeWren();
    statWrite(8'h08);
    check("R6 busy and latch clear after status write", statusByte, 8'hF1);
    check("R6 old protect bits during cycle", bpBits, 2'b00);
    strobeWren();
    check("R12 wren ignored while busy", wel, 0);
    @(negedge clk); @(negedge clk);
    busyLen(n);
    check("R7 busy length", n, CYC_LEN - 4);
    check("R6 new protect bits after cycle", statusByte, 8'hF8);

    strobeWren();
    arrWrite(9'd300, go);
    check("R9 protected address no program strobe", go, 0);
    check("R9 protected address no busy", wip, 0);
    check("R9 latch cleared by blocked write", wel, 0);

    strobeWren();
    arrWrite(9'd100, go);
    check("R9 unprotected address program strobe", go, 1);
    check("R9 unprotected address busy", wip, 1);
    @(negedge clk) wpN = 0;
    busyLen(n);
    wpN = 1;
    check("R8 wp low does not cut cycle", n, CYC_LEN - 1);
    check("R9 array write leaves protect bits", bpBits, 2'b10);

    strobeWren();
    statWrite(8'hF3);
    busyLen(n);
    check("R13 only bits 3..2 of status byte taken", statusByte, 8'hF0);

    setBp(2'b10);
    @(negedge clk) rdStart = 1;
    @(negedge clk) rdStart = 0;
    for (int i = 7; i >= 0; i--) begin
      check("R11 status read bit", statBit, (8'hF8 >> i) & 1);
      @(negedge clk) rdShift = 1;
      @(negedge clk) rdShift = 0;
    end
    check("R11 ninth shift wraps to bit 7", statBit, 1);
    @(negedge clk) rdShift = 1;
    @(negedge clk) rdShift = 0;
    @(negedge clk) rdShift = 1;
    @(negedge clk) rdShift = 0;
    check("R11 wrapped read continues down", statBit, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) rdShift = 1;
      @(negedge clk) rdShift = 0;
    end
    check("R11 wrapped read reaches bit 2", statBit, 0);

    for (int v = 0; v < NVEC; v++) begin
      if (bpBits != VEC[v][11:10]) setBp(VEC[v][11:10]);
      @(negedge clk) chkAddr = VEC[v][9:1];
      #1 check("R10 protect decode", addrProtected, VEC[v][0]);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule